// File: doc/BRIEF.md
# Lowest-Index-First Line Power-Up Sequencer

This block powers up to four line drivers one at a time, so that the inrush of several capacitive loads never lands on the chip together. Turn-on requests are stored in a pending set. Whenever no channel is in its start-up phase, the lowest-numbered pending channel receives its driver-on grant. The block then waits until that channel's current-limit flag drops before it grants the next one. The order in which requests arrived plays no part.

All state moves on rising edges of a slow sequencing clock, nominally 8 kHz. That clock is brought into the system clock domain through a synchronizer and an edge detector. A thermal pre-alarm input stops new requests from being stored, while requests that are already stored are still served. Turn-off requests act at once. When the enable strap is low, the sequencer is bypassed and every driver output simply follows its request.

The controller has three states:
- `ST_IDLE`: no channel is powering up.
- `ST_RAMP`: one channel has been granted and is in its start-up phase.
- `ST_BYPASS`: the enable strap is low.

The transitions are:
- *grant* (IDLE to RAMP): taken on a tick when the pending set is not empty.
- *settle* (RAMP to IDLE): taken on a tick when the ramping channel's current-limit flag is low.
- *abort* (RAMP to IDLE): taken on any clock cycle in which the ramping channel's request is low.
- *strap-off* (any state to BYPASS): taken while `seq_en` is low.
- *strap-on* (BYPASS to IDLE): taken on the first cycle with `seq_en` high.

Top module: `line_pwr_sequencer`

## Requirements
- R1: With the sequencer enabled, at most one driver is newly granted per step. No grant is issued while a granted channel is still in `ST_RAMP`. The ramp ends on the first tick, after the grant tick, at which `line_ilim` of that channel is 0.
- R2: On a grant, the pending channel with the lowest index (bit 0 of each vector is channel 0) is served first, whatever the arrival order. Example: requests from channels 1, 3 and 0 arriving while channel 2 ramps are granted 0, then 1, then 3.
- R3: `pwr_flag[i]` rises on the tick that stores channel i's request. It stays high while the channel is pending or ramping, and falls on the tick at which its ramp ends.
- R4: A current-limit flag on a channel that has already finished ramping does not delay grants to other channels.
- R5: Dropping `line_req[i]` clears `drv_on[i]` combinationally. If channel i was ramping, the ramp is aborted on the next clock edge.
- R6: While `hot_warn` is 1, no new request is stored, but stored requests are still granted. A request still held high is stored on the first tick after `hot_warn` returns to 0.
- R7: With `seq_en` = 0, `drv_on` equals `line_req`, nothing is pending, and `pwr_flag` is 0.
- R8: While `rst_n` is 0, all drivers are off, the pending set is empty, and `pwr_flag` is 0. After release, no driver turns on before a new grant.
- R9: A granted channel whose current-limit flag never falls keeps the sequence stalled until its request is removed.
- R10: State changes only on a detected rising edge of `seq_clk`. A rising edge takes effect at the third `clk` rising edge after it.
- R11: A stored request whose `line_req` bit falls before it is granted leaves the pending set (its `pwr_flag` clears) without being granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_clk | input | 1 | Slow sequencing clock, asynchronous to `clk` |
| seq_en | input | 1 | Enable strap: 1 = sequencer active, 0 = bypass |
| hot_warn | input | 1 | Thermal pre-alarm, hysteresis applied outside the block |
| line_req | input | NCH | Per-channel turn-on request (1 = on) |
| line_ilim | input | NCH | Per-channel current-limit flag |
| drv_on | output | NCH | Per-channel driver-on grant |
| pwr_flag | output | NCH | Per-channel power-on flag (pending or ramping) |

## Verification
The assertions assume that `seq_en`, `hot_warn`, `line_req` and `line_ilim` are synchronous to `clk`. They also assume that `seq_clk` stays at each level for several `clk` periods, so that every rising edge yields exactly one tick. The bench changes every input only on a falling edge of `clk`. It holds each `seq_clk` level for four `clk` periods and keeps `seq_en` at 1 except in the bypass test, so each step of the table covers exactly one tick.

// File: rtl/lps_pkg.sv
package lps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAMP   = 2'd1,
        ST_BYPASS = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lps_tick_sync.sv
module lps_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic tick_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign tick_o = sync_q[STAGES-1] & ~prev_q;

    // R10
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/lps_pick_low.sv
module lps_pick_low #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] first_o
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign first_o[i]  = req_i[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | req_i[i];
    end

    always_comb begin
        // R2
        pick_onehot_chk: assert ($onehot0(first_o) && ((first_o & ~req_i) == '0));
    end
endmodule

// File: rtl/line_pwr_sequencer.sv
module line_pwr_sequencer
    import lps_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           seq_clk,
    input  logic           seq_en,
    input  logic           hot_warn,
    input  logic [NCH-1:0] line_req,
    input  logic [NCH-1:0] line_ilim,
    output logic [NCH-1:0] drv_on,
    output logic [NCH-1:0] pwr_flag
);
    localparam logic [NCH-1:0] NONE = '0;

    seq_state_e     state_q, state_d;
    logic [NCH-1:0] pend_q, pend_d;
    logic [NCH-1:0] on_q, on_d;
    logic [NCH-1:0] cur_q, cur_d;
    logic [NCH-1:0] accept, pend_mid, pick_out;
    logic           tick, cur_live, cur_lim;

    lps_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (seq_clk),
        .tick_o  (tick)
    );

    lps_pick_low #(.N(NCH)) u_pick (
        .req_i   (pend_mid),
        .first_o (pick_out)
    );

    assign cur_live = |(cur_q & line_req);
    assign cur_lim  = |(cur_q & line_ilim);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= NONE;
            on_q    <= NONE;
            cur_q   <= NONE;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            on_q    <= on_d;
            cur_q   <= cur_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        cur_d    = cur_q;
        accept   = NONE;
        if (tick && !hot_warn)
            accept = line_req & ~on_q & ~pend_q;
        pend_mid = (pend_q | accept) & line_req;
        pend_d   = pend_mid;
        on_d     = on_q & line_req;
        if (!seq_en) begin
            state_d = ST_BYPASS;
            pend_d  = NONE;
            on_d    = line_req;
            cur_d   = NONE;
        end else begin
            unique case (state_q)
                ST_BYPASS: state_d = ST_IDLE;
                ST_IDLE: begin
                    if (tick && (pend_mid != NONE)) begin
                        pend_d  = pend_mid & ~pick_out;
                        on_d    = (on_q | pick_out) & line_req;
                        cur_d   = pick_out;
                        state_d = ST_RAMP;
                    end
                end
                ST_RAMP: begin
                    if (!cur_live || (tick && !cur_lim)) begin
                        cur_d   = NONE;
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        drv_on   = seq_en ? (on_q & line_req) : line_req;
        pwr_flag = (state_q == ST_RAMP) ? (pend_q | cur_q) : pend_q;
    end

    // R1
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en && $past(seq_en)) |-> ($countones(on_q & ~$past(on_q)) <= 1));

    // R1
    ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && seq_en) |=> ((on_q & ~$past(on_q)) == NONE));

    // R5
    off_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_en |=> ((on_q & ~$past(line_req)) == NONE));

    // R6
    hot_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_warn && seq_en) |=> ((pend_q & ~$past(pend_q)) == NONE));

    // R7
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_en |=> (on_q == $past(line_req) && pend_q == NONE));

    // R10
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && seq_en) |=> ((on_q & ~$past(on_q)) == NONE));
endmodule

// File: tb/line_pwr_sequencer_test.sv
`timescale 1ns/1ps
module line_pwr_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seq_clk = 1'b0;
    logic       seq_en = 1'b1;
    logic       hot_warn = 1'b0;
    logic [3:0] line_req = 4'b0;
    logic [3:0] line_ilim = 4'b0;
    logic [3:0] drv_on, pwr_flag;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    line_pwr_sequencer uut (
        .clk(clk), .rst_n(rst_n), .seq_clk(seq_clk), .seq_en(seq_en),
        .hot_warn(hot_warn), .line_req(line_req), .line_ilim(line_ilim),
        .drv_on(drv_on), .pwr_flag(pwr_flag)
    );

    // {req, ilim, hot, expected drv_on, expected pwr_flag}; one tick per step
    localparam int NV = 20;
    localparam logic [16:0] VEC [NV] = '{
        {4'b0100, 4'b0000, 1'b0, 4'b0100, 4'b0100}, // grant ch2
        {4'b1111, 4'b0100, 1'b0, 4'b0100, 4'b1111}, // store 0,1,3 (R3)
        {4'b1111, 4'b0100, 1'b0, 4'b0100, 4'b1111}, // stalled (R9)
        {4'b1111, 4'b0000, 1'b0, 4'b0100, 4'b1011}, // ch2 settles
        {4'b1111, 4'b0000, 1'b0, 4'b0101, 4'b1011}, // lowest first: ch0 (R2)
        {4'b1111, 4'b0100, 1'b0, 4'b0101, 4'b1010}, // ch2 overload ignored (R4)
        {4'b1111, 4'b0100, 1'b0, 4'b0111, 4'b1010}, // ch1
        {4'b1111, 4'b0100, 1'b0, 4'b0111, 4'b1000},
        {4'b1111, 4'b0100, 1'b0, 4'b1111, 4'b1000}, // ch3
        {4'b1111, 4'b0000, 1'b0, 4'b1111, 4'b0000},
        {4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000},
        {4'b0001, 4'b0000, 1'b1, 4'b0000, 4'b0000}, // hot: not stored (R6)
        {4'b0001, 4'b0000, 1'b0, 4'b0001, 4'b0001},
        {4'b0001, 4'b0000, 1'b0, 4'b0001, 4'b0000},
        {4'b0011, 4'b0001, 1'b0, 4'b0011, 4'b0010},
        {4'b0111, 4'b0010, 1'b0, 4'b0011, 4'b0110},
        {4'b1111, 4'b0000, 1'b1, 4'b0011, 4'b0100}, // hot: ch3 refused
        {4'b1111, 4'b0000, 1'b1, 4'b0111, 4'b0100}, // stored ch2 served (R6)
        {4'b1111, 4'b0000, 1'b1, 4'b0111, 4'b0000},
        {4'b1111, 4'b0000, 1'b0, 4'b1111, 4'b1000}  // ch3 stored after hot clears
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick_step();
        seq_clk = 1'b1;
        repeat (4) @(negedge clk);
        seq_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset drv", drv_on, 4'b0000);
        chk("R8 reset pwr", pwr_flag, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R6 R9 table walk
        for (int i = 0; i < NV; i++) begin
            line_req  = VEC[i][16:13];
            line_ilim = VEC[i][12:9];
            hot_warn  = VEC[i][8];
            tick_step();
            chk($sformatf("R1 R2 R3 step %0d drv", i), drv_on, VEC[i][7:4]);
            chk($sformatf("R1 R2 R3 step %0d pwr", i), pwr_flag, VEC[i][3:0]);
        end
        line_req = 4'b0000; hot_warn = 1'b0;
        tick_step();

        // R11 withdraw pending, R5 immediate turn-off
        line_req = 4'b0011; line_ilim = 4'b0011;
        tick_step();
        chk("R1 grant ch0 only", drv_on, 4'b0001);
        chk("R3 flags", pwr_flag, 4'b0011);
        line_req = 4'b0001;
        repeat (2) @(negedge clk);
        chk("R11 withdrawn pending", pwr_flag, 4'b0001);
        line_req = 4'b0000;
        #1;
        chk("R5 immediate off", drv_on, 4'b0000);
        @(negedge clk);
        chk("R5 ramp aborted", pwr_flag, 4'b0000);
        line_ilim = 4'b0000;
        tick_step();
        chk("R11 never granted", drv_on, 4'b0000);

        // R7 bypass
        seq_en = 1'b0; line_req = 4'b1010;
        #1;
        chk("R7 bypass drv", drv_on, 4'b1010);
        repeat (2) @(negedge clk);
        chk("R7 bypass pwr", pwr_flag, 4'b0000);
        seq_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 kept on after strap", drv_on, 4'b1010);
        line_req = 4'b0000;
        tick_step();

        // R10 tick latency
        line_req = 4'b0001;
        repeat (3) @(negedge clk);
        chk("R10 no edge no grant", drv_on, 4'b0000);
        seq_clk = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 after 2 edges", drv_on, 4'b0000);
        @(posedge clk);
        @(negedge clk);
        chk("R10 after 3 edges", drv_on, 4'b0001);
        repeat (2) @(negedge clk);
        seq_clk = 1'b0;
        repeat (4) @(negedge clk);

        // R8 reset mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset drv off", drv_on, 4'b0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 stays off", drv_on, 4'b0000);
        line_req = 4'b0000;

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end
endmodule